// File: doc/BRIEF.md
# Digital Constant-Fraction Pulse Timer

This block turns a stream of baseline-corrected waveform samples into pulse arrival times. It takes one signed 12-bit sample on each clock. It builds a bipolar timing signal by adding a sample taken a fixed number of clocks earlier to the current sample, inverted and cut to one quarter. When that signal changes from non-negative to negative, the block reports a hit. The hit time is the index of the last non-negative sample plus a 6-bit fraction, found by linear interpolation between the two sums on either side of the crossing. The block is meant for negative-going pulses, as photomultipliers give them.

A small state machine gates the reports. It starts in `ST_IDLE`. Transition *arm*: `ST_IDLE` goes to `ST_ARMED` when a raw sample is at or below `-ARM_LEVEL`. Transition *fire*: `ST_ARMED` goes to `ST_FIRED` on a crossing. Transition *rearm*: `ST_FIRED` goes back to `ST_IDLE` once the sum is strictly positive again. Every other case holds the current state. There is no dead time between pulses, so several hits can follow each other within one readout window. Each hit is held in a single output register behind a valid/ready handshake.

Top module: `cfd_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `hit_valid_o` is low. The sample counter restarts at 0, the delay line and sums clear, and the state is `ST_IDLE`.
- R2: The timing sum for sample n is x[n-DELAY] - floor(x[n]/4). The quarter is an arithmetic shift right by 2. Samples from before reset count as 0.
- R3: A crossing is only reported if, while in `ST_IDLE`, a sample at or below -ARM_LEVEL was taken at least one sample before the first negative sum. A pulse that never reaches this level produces no hit.
- R4: In `ST_ARMED`, a sum s[n] < 0 that follows s[n-1] >= 0 produces exactly one hit.
- R5: Bits [21:6] of `hit_data_o` hold n-1, the index of the last non-negative sample. Sample indices count clocks from 0 after reset and wrap modulo 2^16.
- R6: Bits [5:0] of `hit_data_o` hold floor(64*s[n-1] / (s[n-1] - s[n])).
- R7: After a hit, no further hit is reported until a strictly positive sum has returned the state to `ST_IDLE` and a new arming sample has been seen.
- R8: A hit appears on `hit_valid_o` right after the clock edge that follows the edge taking in the first negative sample.
- R9: While `hit_valid_o` is high and `hit_ready_i` is low, `hit_valid_o` stays high and `hit_data_o` stays unchanged.
- R10: A hit that arises while the output holds an unaccepted hit is discarded. A hit that arises in the same cycle as an acceptance replaces the accepted one.
- R11: Pulses that follow each other closely each produce their own hit, with no dead time beyond what R7 requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 12 | Signed baseline-corrected sample |
| hit_ready_i | input | 1 | Consumer accepts the presented hit |
| hit_valid_o | output | 1 | A hit is presented |
| hit_data_o | output | 22 | {coarse index[15:0], fraction[5:0]} |

## Verification
The bench builds the block with DELAY=3 and ARM_LEVEL=200. A short delay lets the crossing of a pulse eight samples long fall inside the pulse. A threshold of 200 separates armed pulses of amplitude 1000 from sub-threshold pulses of amplitude 100. The coarse field keeps its full 16 bits. A quiet stretch of 65,536 samples therefore brings a hit right after the counter wraps within reach. With backpressure held for a whole pair of pulses, both the holding behaviour and the discarding behaviour are exercised.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } cfd_state_e;
endpackage

// File: rtl/cfd_delay_line.sv
module cfd_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/cfd_frac_interp.sv
module cfd_frac_interp #(
    parameter int SUM_W  = 14,
    parameter int FRAC_W = 6
) (
    input  logic signed [SUM_W-1:0] sum_prev,
    input  logic signed [SUM_W-1:0] sum_cur,
    output logic        [FRAC_W-1:0] frac
);
    localparam int NUM_W = SUM_W + FRAC_W;

    logic signed [SUM_W:0]   diff;
    logic        [NUM_W-1:0] num;
    logic        [NUM_W-1:0] den;
    logic        [NUM_W-1:0] quo;

    always_comb begin
        diff = {sum_prev[SUM_W-1], sum_prev} - {sum_cur[SUM_W-1], sum_cur};
        num  = {sum_prev, {FRAC_W{1'b0}}};
        den  = NUM_W'(unsigned'(diff));
        quo  = (den == '0) ? '0 : num / den;
        frac = (quo >= NUM_W'(2 ** FRAC_W)) ? {FRAC_W{1'b1}} : quo[FRAC_W-1:0];
    end
endmodule

// File: rtl/cfd_arm_fsm.sv
module cfd_arm_fsm
    import cfd_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int SUM_W     = 14,
    parameter int ARM_LEVEL = 200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] raw,
    input  logic signed [SUM_W-1:0]    sum_cur,
    input  logic signed [SUM_W-1:0]    sum_prev,
    output logic                       fire,
    output cfd_state_e                 state
);
    localparam logic signed [SAMPLE_W-1:0] ARM_NEG = SAMPLE_W'(-ARM_LEVEL);

    cfd_state_e state_nx;
    logic       crossing;
    logic       sum_pos;
    logic       armed_by_raw;

    always_comb begin
        crossing     = sum_cur[SUM_W-1] && !sum_prev[SUM_W-1];
        sum_pos      = !sum_cur[SUM_W-1] && (sum_cur != '0);
        armed_by_raw = (raw <= ARM_NEG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (armed_by_raw) state_nx = ST_ARMED;
            ST_ARMED: if (crossing)     state_nx = ST_FIRED;
            ST_FIRED: if (sum_pos)      state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        fire = (state == ST_ARMED) && crossing;
    end
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
    import cfd_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int DELAY     = 4,
    parameter int ARM_LEVEL = 200,
    parameter int COARSE_W  = 16,
    parameter int FRAC_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic signed [SAMPLE_W-1:0]   sample_i,
    input  logic                         hit_ready_i,
    output logic                         hit_valid_o,
    output logic [COARSE_W+FRAC_W-1:0]   hit_data_o
);
    localparam int SUM_W = SAMPLE_W + 2;

    logic signed [SAMPLE_W-1:0] tap;
    logic signed [SUM_W-1:0]    sum_q, prev_q, sum_d;
    logic signed [SAMPLE_W-1:0] raw_q;
    logic [COARSE_W-1:0]        cnt_q, idx_q;
    logic [FRAC_W-1:0]          frac;
    logic                       fire;
    cfd_state_e                 state;

    cfd_delay_line #(.W(SAMPLE_W), .DEPTH(DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .din(sample_i), .dout(tap)
    );

    always_comb begin
        sum_d = SUM_W'(tap) - SUM_W'(sample_i >>> 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            prev_q <= '0;
            raw_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else begin
            sum_q  <= sum_d;
            prev_q <= sum_q;
            raw_q  <= sample_i;
            cnt_q  <= cnt_q + 1'b1;
            idx_q  <= cnt_q;
        end
    end

    cfd_arm_fsm #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .ARM_LEVEL(ARM_LEVEL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .raw(raw_q), .sum_cur(sum_q), .sum_prev(prev_q),
        .fire(fire), .state(state)
    );

    cfd_frac_interp #(.SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_frac (
        .sum_prev(prev_q), .sum_cur(sum_q), .frac(frac)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid_o <= 1'b0;
            hit_data_o  <= '0;
        end else if (!hit_valid_o || hit_ready_i) begin
            hit_valid_o <= fire;
            if (fire) hit_data_o <= {COARSE_W'(idx_q - 1'b1), frac};
        end
    end
endmodule

// File: rtl/cfd_timer_checker.sv
module cfd_timer_checker
    import cfd_pkg::*;
#(
    parameter int COARSE_W = 16,
    parameter int FRAC_W   = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hit_valid,
    input logic                       hit_ready,
    input logic [COARSE_W+FRAC_W-1:0] hit_data,
    input cfd_state_e                 state
);
    logic [COARSE_W-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    // R1
    always_comb begin
        if (!rst_n) reset_quiet_chk: assert (!hit_valid);
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_data)));

    // R5
    coarse_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && (!$past(hit_valid) || $past(hit_ready)))
        |-> (hit_data[COARSE_W+FRAC_W-1:FRAC_W] == COARSE_W'(cyc - 3)));

    // R4
    fire_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && (!$past(hit_valid) || $past(hit_ready)))
        |-> ($past(state) == ST_ARMED));

    // R3
    no_skip_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_FIRED));
endmodule

bind cfd_timer cfd_timer_checker #(.COARSE_W(COARSE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid_o), .hit_ready(hit_ready_i),
    .hit_data(hit_data_o), .state(state)
);

// File: tb/cfd_timer_test.sv
module cfd_timer_test;
    localparam int D   = 3;
    localparam int ARM = 200;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] sample_i = '0;
    logic               hit_ready_i = 1'b1;
    logic               hit_valid_o;
    logic [21:0]        hit_data_o;

    int checks = 0, fails = 0, accepted = 0, cycles = 0;
    logic [21:0] last_data;

    cfd_timer #(.DELAY(D), .ARM_LEVEL(ARM)) uut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .hit_ready_i(hit_ready_i),
        .hit_valid_o(hit_valid_o), .hit_data_o(hit_data_o)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    integer hist[$];
    integer m_sum, m_psum, m_raw, m_idx, m_cnt, m_st, m_oc, m_of, m_xd;
    bit     m_ov, m_fire;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < D; i++) hist.push_back(0);
            m_sum = 0; m_psum = 0; m_raw = 0; m_idx = 0; m_cnt = 0;
            m_st = 0; m_ov = 0; m_oc = 0; m_of = 0;
        end else begin
            m_fire = (m_st == 1) && (m_sum < 0) && (m_psum >= 0);
            if (!(m_ov && !hit_ready_i)) begin
                m_ov = m_fire;
                if (m_fire) begin
                    m_oc = (m_idx + 65535) % 65536;
                    m_of = (m_psum * 64) / (m_psum - m_sum);
                end
            end
            case (m_st)
                0: if (m_raw <= -ARM) m_st = 1;
                1: if (m_fire) m_st = 2;
                default: if (m_sum > 0) m_st = 0;
            endcase
            m_xd = hist[D-1];
            void'(hist.pop_back());
            hist.push_front(integer'(sample_i));
            m_psum = m_sum;
            m_sum  = m_xd - (integer'(sample_i) >>> 2);
            m_raw  = integer'(sample_i);
            m_idx  = m_cnt;
            m_cnt  = (m_cnt + 1) % 65536;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (hit_valid_o !== m_ov) begin
                fails++;
                $display("FAIL R8/R3/R4/R7/R10: valid=%0b expected %0b", hit_valid_o, m_ov);
            end else if (m_ov) begin
                checks++;
                if (hit_data_o !== 22'((m_oc << 6) | m_of)) begin
                    fails++;
                    $display("FAIL R5/R6/R2: data=%h expected %h", hit_data_o, 22'((m_oc << 6) | m_of));
                end
            end
            if (hit_valid_o && hit_ready_i) begin
                accepted++;
                last_data = hit_data_o;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic put(input int v);
        @(posedge clk); #2 sample_i = 12'(v);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) put(0);
    endtask

    task automatic pulse(input int a);
        put(-a / 8); put(-a / 2); put(-a); put(-3 * a / 4);
        put(-a / 2); put(-a / 4); put(-a / 8); put(0);
    endtask

    task automatic expect_count(input int base, input int want, input string tag);
        checks++;
        if (accepted - base != want) begin
            fails++;
            $display("FAIL %s: hits=%0d expected %0d", tag, accepted - base, want);
        end
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (hit_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b expected 0", hit_valid_o);
        end
        @(posedge clk); #2 rst_n = 1'b1;
        #3;
        checks++;
        if (hit_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b expected 0", hit_valid_o);
        end
        quiet(5);

        // R4 R6: single armed pulse, crossing between sums 63 and -375
        base = accepted;
        pulse(1000); quiet(8);
        expect_count(base, 1, "R4");
        checks++;
        if (last_data[5:0] !== 6'd9) begin
            fails++;
            $display("FAIL R6: frac=%0d expected 9", last_data[5:0]);
        end

        // R3: sub-threshold and positive pulses never arm
        base = accepted;
        pulse(100); quiet(6); pulse(-1500); quiet(8);
        expect_count(base, 0, "R3");

        // R7 R11: closely spaced pulses, each its own hit
        base = accepted;
        pulse(1200); pulse(800); quiet(2); pulse(1600); quiet(8);
        expect_count(base, 3, "R11");

        // R9 R10: backpressure over two pulses, second discarded
        base = accepted;
        @(posedge clk); #2 hit_ready_i = 1'b0;
        pulse(900); quiet(2); pulse(1400); quiet(10);
        @(posedge clk); #2 hit_ready_i = 1'b1;
        quiet(4);
        expect_count(base, 1, "R10");

        // R5: hit just after the coarse counter wraps
        quiet(65536 - (m_cnt % 65536) - 2);
        base = accepted;
        pulse(1000); quiet(8);
        expect_count(base, 1, "R5");
        checks++;
        if (last_data[21:6] > 16'd10) begin
            fails++;
            $display("FAIL R5: coarse=%0d expected small after wrap", last_data[21:6]);
        end

        // R2: varied amplitudes including odd values and clipping edge
        pulse(2047); pulse(333); quiet(3); pulse(1999); quiet(10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule